// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block listens to a keyboard's clock and data wires and turns each eleven-edge frame into an 8-bit scan code. Both wires first pass through flop synchronizers. A falling edge of the synchronized keyboard clock is detected in the system clock domain, and the data wire is sampled at that edge. A framing state machine keeps track of the edge position. Completed codes go into a small ring buffer. A host pulls them out one at a time through a valid/read strobe pair.

The key-release prefix (0xF0) is never handed to the reader. When the next entry to read is the prefix, the block shows the code that follows it instead. A read then removes both entries and raises a release flag, which stays set until the host acknowledges it. If the keyboard clock stays still for longer than a timeout, the next edge starts a new frame. This recovers from a partial frame without any check of the start or stop bits.

The framer's states are FR_IDLE, FR_DATA, FR_PARITY and FR_STOP:
- An edge in FR_IDLE is the start edge. It clears the bit index and the partial byte and moves to FR_DATA.
- Each edge in FR_DATA stores one bit. The eighth bit moves the framer to FR_PARITY.
- An edge in FR_PARITY moves to FR_STOP.
- An edge in FR_STOP emits the code and returns to FR_IDLE.
- A stale edge, one that arrives after the timeout has expired, is handled as if the state were FR_IDLE.

Top module: `ps2_keyrx`

## Requirements
- R1: After reset, code_valid and brk_flag are both low.
- R2: Frame edges 2 to 9 carry the data bits, least significant bit first. The assembled byte is presented on code_out with code_valid high.
- R3: The values on the data wire at edges 1, 10 and 11 (start, parity, stop) have no effect on the code or on its acceptance.
- R4: Codes are delivered in the order they arrived. A rd_en pulse while code_valid is high removes exactly the presented code.
- R5: If more than the timeout has passed since the previous falling edge, the partial byte and edge count are discarded and the new edge is treated as edge 1.
- R6: The buffer has 16 slots and holds at most 15 codes. A code completed while 15 are held is dropped.
- R7: When the oldest entry is 0xF0, code_out shows the entry after it. A read removes both entries and sets brk_flag.
- R8: A lone 0xF0 with no following code leaves code_valid low.
- R9: A brk_take pulse clears brk_flag. A read that consumes 0xF0 in the same cycle wins, and the flag stays set.
- R10: Once every buffered code has been read, code_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_i | input | 1 | Keyboard clock wire (asynchronous) |
| kb_dat_i | input | 1 | Keyboard data wire (asynchronous) |
| rd_en | input | 1 | Read strobe, removes the presented code |
| brk_take | input | 1 | Acknowledge strobe, clears brk_flag |
| code_valid | output | 1 | A readable code is available |
| code_out | output | 8 | Presented scan code |
| brk_flag | output | 1 | Key-release flag |

## Verification
The bench sends frames with wrong parity, a stop bit of 0 and a start bit of 1. A framer that checked those bits would drop the codes. It sends a release prefix alone and then completes it. A design that counted the prefix as readable would raise code_valid early, or would hand 0xF0 to the reader. It abandons a frame after five edges and waits out the timeout. A design that did not resynchronize would shift every later code. It also sends sixteen codes into a 15-entry buffer. An off-by-one in the full test would either deliver the sixteenth code or overwrite the oldest one.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_DATA,
        FR_PARITY,
        FR_STOP
    } fr_state_t;
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kb_clk_i,
    input  logic kb_dat_i,
    output logic kb_fall,
    output logic kb_dat
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             clk_prev;

    assign raw = {kb_dat_i, kb_clk_i};

    // one synchronizer chain per wire, both idle high
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= synced[0];
    end

    assign kb_fall = clk_prev & ~synced[0];
    assign kb_dat  = synced[1];
endmodule

// File: rtl/ps2rx_framer.sv
module ps2rx_framer
    import ps2rx_pkg::*;
#(
    parameter int TMO_CYC = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_fall,
    input  logic              kb_dat,
    output logic              frm_vld,
    output logic [CODE_W-1:0] frm_code
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam int BW = $clog2(CODE_W);

    fr_state_t         state, nxt_state, eff_state;
    logic [CW-1:0]     idle_cnt;
    logic [BW-1:0]     bit_idx;
    logic [CODE_W-1:0] shreg;
    logic              stale, clr, sample, done;

    assign stale = (idle_cnt == CW'(TMO_CYC));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= nxt_state;
    end

    // next state and strobes
    always_comb begin
        eff_state = stale ? FR_IDLE : state;
        nxt_state = state;
        clr       = 1'b0;
        sample    = 1'b0;
        done      = 1'b0;
        if (kb_fall) begin
            unique case (eff_state)
                FR_IDLE: begin
                    clr       = 1'b1;
                    nxt_state = FR_DATA;
                end
                FR_DATA: begin
                    sample = 1'b1;
                    if (bit_idx == BW'(CODE_W - 1)) nxt_state = FR_PARITY;
                end
                FR_PARITY: nxt_state = FR_STOP;
                FR_STOP: begin
                    done      = 1'b1;
                    nxt_state = FR_IDLE;
                end
            endcase
        end
    end

    // datapath: silence counter, bit index, shift byte, output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            frm_vld  <= 1'b0;
            frm_code <= '0;
        end else begin
            if (kb_fall)     idle_cnt <= '0;
            else if (!stale) idle_cnt <= idle_cnt + 1'b1;

            if (clr) begin
                bit_idx <= '0;
                shreg   <= '0;
            end else if (sample) begin
                bit_idx        <= bit_idx + 1'b1;
                shreg[bit_idx] <= kb_dat;
            end

            frm_vld <= done;
            if (done) frm_code <= shreg;
        end
    end
endmodule

// File: rtl/ps2rx_ring.sv
module ps2rx_ring
    import ps2rx_pkg::*;
#(
    parameter int                DEPTH = 16,
    parameter logic [CODE_W-1:0] BRK   = 8'hF0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [CODE_W-1:0]         push_data,
    input  logic                      rd_en,
    input  logic                      brk_take,
    output logic                      code_valid,
    output logic [CODE_W-1:0]         code_out,
    output logic                      brk_flag,
    output logic [$clog2(DEPTH):0]    level,
    output logic [CODE_W-1:0]         head
);
    localparam int AW = $clog2(DEPTH);

    logic [CODE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr, diff;
    logic [CODE_W-1:0] nxt;
    logic              full, head_brk, pop;

    assign diff     = wr_ptr - rd_ptr;
    assign level    = {1'b0, diff};
    assign full     = (level == (AW+1)'(DEPTH - 1));
    assign head     = mem[rd_ptr];
    assign nxt      = mem[rd_ptr + 1'b1];
    assign head_brk = (head == BRK);

    assign code_valid = (level != '0) && (!head_brk || level >= (AW+1)'(2));
    assign code_out   = head_brk ? nxt : head;
    assign pop        = rd_en && code_valid;

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            brk_flag <= 1'b0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
            if (pop) rd_ptr <= rd_ptr + (head_brk ? AW'(2) : AW'(1));
            if (pop && head_brk) brk_flag <= 1'b1;
            else if (brk_take)   brk_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ps2_keyrx.sv
module ps2_keyrx
    import ps2rx_pkg::*;
#(
    parameter int                CLK_HZ     = 250_000_000,
    parameter int                TIMEOUT_US = 250_000,
    parameter int                DEPTH      = 16,
    parameter int                SYNC_STG   = 2,
    parameter logic [CODE_W-1:0] BRK_CODE   = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_clk_i,
    input  logic              kb_dat_i,
    input  logic              rd_en,
    input  logic              brk_take,
    output logic              code_valid,
    output logic [CODE_W-1:0] code_out,
    output logic              brk_flag
);
    localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
    localparam int LW      = $clog2(DEPTH) + 1;

    logic              kb_fall, kb_dat, frm_vld;
    logic [CODE_W-1:0] frm_code, head_code;
    logic [LW-1:0]     fill_lvl;

    ps2rx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .kb_clk_i (kb_clk_i),
        .kb_dat_i (kb_dat_i),
        .kb_fall  (kb_fall),
        .kb_dat   (kb_dat)
    );

    ps2rx_framer #(.TMO_CYC(TMO_CYC)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .kb_fall  (kb_fall),
        .kb_dat   (kb_dat),
        .frm_vld  (frm_vld),
        .frm_code (frm_code)
    );

    ps2rx_ring #(.DEPTH(DEPTH), .BRK(BRK_CODE)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (frm_vld),
        .push_data  (frm_code),
        .rd_en      (rd_en),
        .brk_take   (brk_take),
        .code_valid (code_valid),
        .code_out   (code_out),
        .brk_flag   (brk_flag),
        .level      (fill_lvl),
        .head       (head_code)
    );
endmodule

// File: rtl/ps2_keyrx_chk.sv
module ps2_keyrx_chk #(
    parameter int         DEPTH = 16,
    parameter logic [7:0] BRK   = 8'hF0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_en,
    input logic                   brk_take,
    input logic                   code_valid,
    input logic                   brk_flag,
    input logic                   push,
    input logic [7:0]             head_code,
    input logic [$clog2(DEPTH):0] fill_lvl
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic head_brk, rd_ok;
    assign head_brk = (head_code == BRK);
    assign rd_ok    = rd_en && code_valid;

    AST_VALID_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> fill_lvl != '0); // R10
    AST_LONE_BREAK_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_lvl == LW'(1) && head_brk) |-> !code_valid); // R8
    AST_BREAK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && head_brk) |=> brk_flag); // R7
    AST_TAKE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_take && !(rd_ok && head_brk)) |=> !brk_flag); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fill_lvl == LW'(DEPTH - 1) && !rd_ok) |=> fill_lvl == LW'(DEPTH - 1)); // R6
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !head_brk && !push) |=> fill_lvl == $past(fill_lvl) - 1'b1); // R4
endmodule

bind ps2_keyrx ps2_keyrx_chk #(.DEPTH(DEPTH), .BRK(BRK_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .brk_take   (brk_take),
    .code_valid (code_valid),
    .brk_flag   (brk_flag),
    .push       (frm_vld),
    .head_code  (head_code),
    .fill_lvl   (fill_lvl)
);

// File: tb/ps2_keyrx_test.sv
`timescale 1ns/1ps
module ps2_keyrx_test;
    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       kb_clk_i, kb_dat_i, rd_en, brk_take, mon_en;
    logic       code_valid, brk_flag;
    logic [7:0] code_out;

    int errors = 0;
    int checks = 0;
    logic [8:0] exp_q[$];

    always #2 clk = ~clk;

    ps2_keyrx #(.CLK_HZ(250_000_000), .TIMEOUT_US(2)) uut (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i),
        .rd_en(rd_en), .brk_take(brk_take), .code_valid(code_valid),
        .code_out(code_out), .brk_flag(brk_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge_bit(input bit b);
        @(negedge clk) kb_dat_i = b;
        repeat (HALF) @(negedge clk);
        kb_clk_i = 1'b0;
        repeat (HALF) @(negedge clk);
        kb_clk_i = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit st, input bit par, input bit sp);
        edge_bit(st);
        for (int i = 0; i < 8; i++) edge_bit(d[i]);
        edge_bit(par);
        edge_bit(sp);
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic send_code(input logic [7:0] d);
        send_frame(d, 1'b0, ~^d, 1'b1);
    endtask

    task automatic expect_code(input bit brk, input logic [7:0] d);
        exp_q.push_back({brk, d});
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, "R4 missing codes", exp_q.size(), 0);
        repeat (10) @(negedge clk);
        chk(code_valid == 1'b0, "R10 leftover entry", code_valid, 0);
    endtask

    // monitor: pops expected items as the design presents codes
    initial begin
        rd_en = 1'b0;
        brk_take = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_en && code_valid) begin
                logic [8:0] e;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected code", code_out, 0);
                    e = {1'b0, code_out};
                end else begin
                    e = exp_q.pop_front();
                end
                chk(code_out == e[7:0], "R2 code value", code_out, e[7:0]);
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
                chk(brk_flag == e[8], "R7 release flag", brk_flag, e[8]);
                brk_take = 1'b1;
                @(negedge clk);
                brk_take = 1'b0;
                chk(brk_flag == 1'b0, "R9 flag cleared", brk_flag, 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; kb_clk_i = 1'b1; kb_dat_i = 1'b1; mon_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(code_valid == 1'b0, "R1 valid after reset", code_valid, 0);
        chk(brk_flag == 1'b0, "R1 flag after reset", brk_flag, 0);

        // R2 / R4: several patterns in order
        mon_en = 1'b1;
        expect_code(0, 8'h1C); send_code(8'h1C);
        expect_code(0, 8'h00); send_code(8'h00);
        expect_code(0, 8'hFF); send_code(8'hFF);
        expect_code(0, 8'hA5); send_code(8'hA5);
        drain();

        // R3: start=1, wrong parity, stop=0 all ignored
        expect_code(0, 8'h3A); send_frame(8'h3A, 1'b1, ^8'h3A, 1'b0);
        drain();

        // R7: prefix folded into the flag of the following code
        expect_code(1, 8'h1C); expect_code(0, 8'h32);
        send_code(8'hF0); send_code(8'h1C); send_code(8'h32);
        drain();

        // R8: lone prefix not readable
        mon_en = 1'b0;
        send_code(8'hF0);
        repeat (30) @(negedge clk);
        chk(code_valid == 1'b0, "R8 lone prefix", code_valid, 0);
        send_code(8'h29);
        chk(code_valid == 1'b1, "R8 prefix completed", code_valid, 1);
        chk(code_out == 8'h29, "R7 code behind prefix", code_out, 8'h29);
        expect_code(1, 8'h29);
        mon_en = 1'b1;
        drain();

        // R5: abandoned partial frame, then silence beyond the timeout
        for (int i = 0; i < 5; i++) edge_bit(i[0]);
        repeat (1200) @(negedge clk);
        expect_code(0, 8'h5B); send_code(8'h5B);
        drain();

        // R6: sixteen codes into fifteen slots
        mon_en = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (i < 15) expect_code(0, 8'h40 + 8'(i));
            send_code(8'h40 + 8'(i));
        end
        chk(code_valid == 1'b1, "R6 buffer holds codes", code_valid, 1);
        chk(code_out == 8'h40, "R6 oldest kept", code_out, 8'h40);
        mon_en = 1'b1;
        drain();

        // R4: normal operation after wrap
        expect_code(0, 8'h11); send_code(8'h11);
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule